// File: doc/BRIEF.md
# GPIO Interrupt Path Selector

This block sits between three banks of general-purpose pins and the platform interrupt controller. Each of the 96 pins raises its own interrupt request. A routing map chooses one of two paths for every pin. The pin can drive a dedicated direct line of its own. It can instead be merged into the one shared line that serves its bank. The map lives in a small configuration register set that belongs to none of the banks. A bank may send any number of its pins to the shared line, from none to all 32.

Software writes one 32-bit routing word per bank through a simple write port. While a pin is routed to the shared line, its direct line is held low. A request therefore never shows up on both paths. All outputs are registered, so every result appears exactly one clock after the request that causes it.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is high, every direct and shared output is low. After reset, every routing bit is 0, which means every pin is direct.
- R2: A pin whose routing bit is 0 drives its direct output with its request value, sampled at the previous clock edge.
- R3: A pin whose routing bit is 1 holds its direct output low, whatever its request.
- R4: Shared output b is high one cycle after any request of bank b whose routing bit is 1 is high.
- R5: Requests from pins whose routing bit is 0 never raise their bank's shared output.
- R6: A write with byte address 0x0 sets the routing word of bank 0. Address 0x4 sets bank 1 and address 0x8 sets bank 2. Bit i of the word routes pin i of that bank, which is global pin 32*b+i.
- R7: A write to byte address 0xC changes no routing bit.
- R8: A bank works with all 32 pins routed to its shared line, and it works with none of them routed there.
- R9: Latency is exactly one cycle. A routing write is used for requests starting with the clock edge that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Routing word write strobe |
| cfg_addr | input | 4 | Byte address of the routing word |
| cfg_wdata | input | 32 | Routing word, where 1 selects the shared line |
| irq_req | input | 96 | Per-pin interrupt requests, bank-major order |
| direct_irq | output | 96 | Gated per-pin direct interrupt lines |
| shared_irq | output | 3 | One shared interrupt line per bank |

## Verification
The properties assume that requests and routing writes are synchronous to the clock. They also assume that the two low bits of the write address are zero. The bench drives every request and write on the falling edge. It uses only word-aligned addresses, and it uses the unmapped offset 0xC only to check that such a write is ignored. The exclusivity and gating properties compare each output with the routing map and the requests as they stood one edge earlier. The stimulus therefore holds a write for a full cycle so that the map and the outputs line up.

// File: rtl/gpio_irq_router_pkg.sv
package gpio_irq_router_pkg;
  localparam int unsigned BANKS_DEF = 3;
  localparam int unsigned PINS_DEF  = 32;
  localparam int unsigned AW_DEF    = 4;
  localparam int unsigned WORD_W    = 32;
endpackage

// File: rtl/gpio_route_cfg.sv
module gpio_route_cfg #(
  parameter int unsigned BANKS = gpio_irq_router_pkg::BANKS_DEF,
  parameter int unsigned PINS  = gpio_irq_router_pkg::PINS_DEF,
  parameter int unsigned AW    = gpio_irq_router_pkg::AW_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [PINS-1:0]       wdata,
  output logic [BANKS*PINS-1:0] route_map
);
  localparam int unsigned IDX_W = AW - 2;

  logic [IDX_W-1:0] word_idx;
  assign word_idx = addr[AW-1:2];

  for (genvar b = 0; b < BANKS; b++) begin : g_word
    logic hit;
    assign hit = we && (word_idx == IDX_W'(b));
    always_ff @(posedge clk) begin
      if (rst)      route_map[b*PINS +: PINS] <= '0;
      else if (hit) route_map[b*PINS +: PINS] <= wdata;
    end
  end
endmodule

// File: rtl/gpio_bank_router.sv
module gpio_bank_router #(
  parameter int unsigned PINS = gpio_irq_router_pkg::PINS_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] req,
  input  logic [PINS-1:0] to_shared,
  output logic [PINS-1:0] direct_q,
  output logic            shared_q
);
  logic [PINS-1:0] direct_d;
  logic            shared_d;

  always_comb begin
    direct_d = req & ~to_shared;
    shared_d = |(req & to_shared);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      direct_q <= '0;
      shared_q <= 1'b0;
    end else begin
      direct_q <= direct_d;
      shared_q <= shared_d;
    end
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int unsigned BANKS = gpio_irq_router_pkg::BANKS_DEF,
  parameter int unsigned PINS  = gpio_irq_router_pkg::PINS_DEF,
  parameter int unsigned AW    = gpio_irq_router_pkg::AW_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [PINS-1:0]       cfg_wdata,
  input  logic [BANKS*PINS-1:0] irq_req,
  output logic [BANKS*PINS-1:0] direct_irq,
  output logic [BANKS-1:0]      shared_irq
);
  localparam int unsigned TOTAL = BANKS * PINS;

  logic [TOTAL-1:0] route_map;

  gpio_route_cfg #(.BANKS(BANKS), .PINS(PINS), .AW(AW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .route_map (route_map)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gpio_bank_router #(.PINS(PINS)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .req       (irq_req[b*PINS +: PINS]),
      .to_shared (route_map[b*PINS +: PINS]),
      .direct_q  (direct_irq[b*PINS +: PINS]),
      .shared_q  (shared_irq[b])
    );
  end
endmodule

// File: rtl/gpio_irq_router_checker.sv
module gpio_irq_router_checker #(
  parameter int unsigned BANKS = gpio_irq_router_pkg::BANKS_DEF,
  parameter int unsigned PINS  = gpio_irq_router_pkg::PINS_DEF,
  parameter int unsigned AW    = gpio_irq_router_pkg::AW_DEF
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_we,
  input logic [AW-1:0]         cfg_addr,
  input logic [BANKS*PINS-1:0] irq_req,
  input logic [BANKS*PINS-1:0] direct_irq,
  input logic [BANKS-1:0]      shared_irq,
  input logic [BANKS*PINS-1:0] route_map
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (direct_irq == '0 && shared_irq == '0));

  assert_direct_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (direct_irq & ~$past(irq_req)) == '0);

  assert_muxed_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (direct_irq & $past(route_map)) == '0);

  assert_hole_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == AW'(12)) |=> $stable(route_map));

  for (genvar b = 0; b < BANKS; b++) begin : g_chk
    assert_shared_cause_R4: assert property (@(posedge clk) disable iff (rst)
      shared_irq[b] |-> $past(|irq_req[b*PINS +: PINS]));

    assert_direct_excluded_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(|(irq_req[b*PINS +: PINS] & route_map[b*PINS +: PINS]))
        |-> !shared_irq[b]);
  end
endmodule

bind gpio_irq_router gpio_irq_router_checker #(.BANKS(BANKS), .PINS(PINS), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .irq_req    (irq_req),
  .direct_irq (direct_irq),
  .shared_irq (shared_irq),
  .route_map  (route_map)
);

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int BANKS = 3;
  localparam int PINS  = 32;
  localparam int TOTAL = BANKS * PINS;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [3:0]       cfg_addr = '0;
  logic [31:0]      cfg_wdata = '0;
  logic [TOTAL-1:0] irq_req = '0;
  logic [TOTAL-1:0] direct_irq;
  logic [BANKS-1:0] shared_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [TOTAL-1:0] model_map = '0;
  logic [TOTAL-1:0] exp_dir_q[$];
  logic [BANKS-1:0] exp_sh_q[$];
  string            tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_router uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_req(irq_req),
    .direct_irq(direct_irq), .shared_irq(shared_irq)
  );

  task automatic write_word(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 4'd12) model_map[a[3:2]*PINS +: PINS] = d;
  endtask

  task automatic apply(input logic [TOTAL-1:0] r, input string tag);
    logic [BANKS-1:0] sh;
    @(negedge clk);
    irq_req = r;
    for (int b = 0; b < BANKS; b++)
      sh[b] = |(r[b*PINS +: PINS] & model_map[b*PINS +: PINS]);
    exp_dir_q.push_back(r & ~model_map);
    exp_sh_q.push_back(sh);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_dir_q.size() > 0) begin
      logic [TOTAL-1:0] ed;
      logic [BANKS-1:0] es;
      string t;
      ed = exp_dir_q.pop_front();
      es = exp_sh_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if (direct_irq !== ed || shared_irq !== es) begin
        errors++;
        $display("FAIL %s: direct=%h shared=%b expected direct=%h shared=%b",
                 t, direct_irq, shared_irq, ed, es);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    irq_req = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (direct_irq !== '0 || shared_irq !== '0) begin
      errors++;
      $display("FAIL R1 reset: direct=%h shared=%b expected direct=0 shared=0",
               direct_irq, shared_irq);
    end
    rst = 1'b0;
    irq_req = '0;

    // R1, R2: default map is all direct
    apply({32'hDEADBEEF, 32'h12345678, 32'h80000001}, "R1 R2 default direct");
    apply('0, "R2 idle");
    // R9: consecutive changes each appear exactly one cycle later
    apply({32'h0, 32'hFFFFFFFF, 32'h0}, "R9 step one");
    apply({32'hFFFFFFFF, 32'h0, 32'h1}, "R9 step two");

    // R6, R8: bank0 half muxed, bank1 all muxed, bank2 none
    write_word(4'h0, 32'h0000FFFF);
    write_word(4'h4, 32'hFFFFFFFF);
    write_word(4'h8, 32'h00000000);
    apply({32'h0000FFFF, 32'h00000000, 32'hFFFF0000}, "R5 R8 only direct pins");
    apply({32'h0, 32'h40000000, 32'h00000001}, "R3 R4 R8 muxed pins");
    apply({32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF}, "R3 R4 all high");

    // R7: unmapped offset leaves map unchanged
    write_word(4'hC, 32'hFFFFFFFF);
    apply({32'hFFFFFFFF, 32'h0, 32'hFFFF0000}, "R7 hole write ignored");

    // R6: bank2 word lands on global pins 68..71
    write_word(4'h8, 32'h000000F0);
    apply({32'h00000010, 32'h0, 32'h0}, "R6 bank2 pin4 muxed");
    apply({32'h00000108, 32'h0, 32'h0}, "R6 R5 bank2 neighbours direct");

    // R9: write followed at once by request uses the new map
    write_word(4'h0, 32'h00000000);
    apply({32'h0, 32'h0, 32'h0000FFFF}, "R9 new map immediate");
    apply('0, "R9 settle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule